// File: doc/BRIEF.md
# Serial EEPROM Status Command Handler

This block is the byte-level command engine of a serial EEPROM slave on a single-wire bus. A bit-level physical layer below it detects the start of each transaction, decodes incoming bytes and reports the acknowledge bit the master sends after each byte: MAK means continue and NoMAK means end. For every byte it accepts, the engine answers with a slave acknowledge (SAK). It also loads outgoing status bytes for the physical layer to shift out. For the memory array controller it raises whole-array fill requests and a write-in-progress flag.

The engine owns the four live status bits: the write-in-progress flag, the write-enable latch and two block-protect bits. It decodes these commands: write-enable set, write-enable clear, status read, status write, erase-to-zero and fill-with-ones. The device address and every opcode are parameters. Any command that changes state takes effect only when its last byte carries NoMAK. If a command is rejected, the engine stays silent and sends no SAK. A status read keeps repeating as long as the master answers each status byte with MAK, and every repeat carries the current flags.

During a read slot, the physical layer pulses `byte_valid_i` when the slot ends and reports the master's acknowledge on `mak_i`; `rx_byte_i` is ignored in that slot. A SAK is a one-cycle pulse on `sak_o` in the cycle after the byte; no pulse means NoSAK.

Top module: `sse_status_engine`

## Requirements
- R1: A status byte carries the write-in-progress flag at bit 0, the write-enable latch at bit 1, protect bit 0 at bit 2 and protect bit 1 at bit 3; bits 7 to 4 are always 0.
- R2: The write-enable command ending with NoMAK is acknowledged and sets the latch; the write-disable command ending with NoMAK is acknowledged and clears it.
- R3: If the first byte after a start is not the device address, no byte of that transaction gets a SAK and no status byte is loaded.
- R4: In a status read, each MAK after a status byte gets a SAK and loads a fresh status byte from the live flags; a NoMAK gets a SAK and ends the read with no further load.
- R5: A status read is served while an internal write cycle is running and reports bit 0 as 1.
- R6: A status write (opcode with MAK, then data with NoMAK) is acknowledged, copies data bits 3:2 into the protect bits, and starts an internal write cycle (`wip_o` high in the cycle of the SAK); a read during that cycle returns the new protect bits.
- R7: A command other than the status read whose final byte carries MAK gets no SAK and changes nothing: no latch change, no protect change, no fill request.
- R8: With the latch set and both protect bits 0, erase-to-zero and fill-with-ones ending with NoMAK are acknowledged and pulse `fill_req_o` in the SAK cycle, with `fill_ones_o` 0 for erase and 1 for fill, and they start an internal write cycle.
- R9: Erase-to-zero and fill-with-ones get no SAK and no fill request while either protect bit is 1.
- R10: While an internal write cycle runs, every command except the status read gets no SAK and has no effect.
- R11: A status write, erase or fill issued while the latch is clear gets no SAK and has no effect.
- R12: An internal write cycle keeps `wip_o` high for exactly `TWC_CYCLES` cycles, and the latch is clear when it ends.
- R13: Reset clears the latch, the write-in-progress flag and both protect bits, and the outputs are idle.
- R14: An opcode that matches no command gets no SAK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse: a new transaction begins, the next byte is the device address |
| byte_valid_i | input | 1 | Pulse: a byte (or read slot) has completed |
| rx_byte_i | input | 8 | Received byte, valid with `byte_valid_i` |
| mak_i | input | 1 | Master acknowledge for the completed byte: 1 MAK, 0 NoMAK |
| sak_o | output | 1 | Pulse: send SAK for the byte just completed |
| tx_load_o | output | 1 | Pulse: `tx_byte_o` holds the next byte to transmit |
| tx_byte_o | output | 8 | Status byte to transmit |
| fill_req_o | output | 1 | Pulse: start a whole-array fill |
| fill_ones_o | output | 1 | Fill value: 1 for all ones, 0 for all zeros |
| wip_o | output | 1 | Internal write cycle in progress |

## Verification
The bench builds the engine with `TWC_CYCLES` set to 20 and passes the device address 0xA0 and the opcodes explicitly: enable 0x96, disable 0x91, status read 0x05, status write 0x6E, erase 0x6D, fill 0x67. The unused byte 0x3C serves as an unknown opcode. The short write cycle lets one polled status read cross the end of a cycle, so the bench sees the busy flag and the latch drop between two consecutive repeats. It also lets the bench count the exact length of the busy window and issue rejected commands inside it.

// File: rtl/sse_pkg.sv
// Shared types for the status command engine.
// Assumes: status byte layout {4'b0, protect[1:0], latch, busy}.
package sse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_READ
    } sse_state_e;

    // Assemble the status byte from live flags.
    function automatic logic [7:0] pack_status(input logic busy,
                                               input logic latch,
                                               input logic [1:0] prot);
        return {4'b0000, prot, latch, busy};
    endfunction

endpackage

// File: rtl/sse_wc_timer.sv
// Internal write-cycle timer: holds busy for TWC_CYCLES cycles after start.
// Assumes TWC_CYCLES >= 2 and that start_i never arrives while busy.
module sse_wc_timer #(
    parameter int TWC_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(TWC_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    // Load the down-counter on start, clear busy when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(TWC_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Last busy cycle marker.
    always_comb done_o = busy_q && (cnt_q == '0);

    assign busy_o = busy_q;
endmodule

// File: rtl/sse_status_regs.sv
// Write-enable latch and protect bits.
// Assumes set and clear strobes are mutually exclusive with cycle completion.
module sse_status_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set_i,
    input  logic       wel_clr_i,
    input  logic       cyc_done_i,
    input  logic       bp_wr_i,
    input  logic [1:0] bp_d_i,
    output logic       wel_o,
    output logic [1:0] bp_o
);
    logic       wel_q;
    logic [1:0] bp_q;

    // Latch: set by enable command, cleared by disable command or cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wel_q <= 1'b0;
        else if (wel_clr_i || cyc_done_i) wel_q <= 1'b0;
        else if (wel_set_i)              wel_q <= 1'b1;
    end

    // Protect bits: written only by an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n)       bp_q <= 2'b00;
        else if (bp_wr_i) bp_q <= bp_d_i;
    end

    assign wel_o = wel_q;
    assign bp_o  = bp_q;
endmodule

// File: rtl/sse_seq_fsm.sv
// Transaction sequencer: matches the address, decodes the opcode, applies
// the acknowledge and permission rules, and emits registered SAK, status
// loads and fill requests. State side effects are combinational strobes
// that take effect on the edge that consumes the byte.
// Assumes start_i takes priority over a coincident byte_valid_i.
module sse_seq_fsm
    import sse_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hA0,
    parameter logic [7:0] OP_WREN  = 8'h96,
    parameter logic [7:0] OP_WRDI  = 8'h91,
    parameter logic [7:0] OP_RDSR  = 8'h05,
    parameter logic [7:0] OP_WRSR  = 8'h6E,
    parameter logic [7:0] OP_ERAL  = 8'h6D,
    parameter logic [7:0] OP_SETAL = 8'h67
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       mak_i,
    input  logic       wip_i,
    input  logic       wel_i,
    input  logic [1:0] bp_i,
    output logic       wel_set_o,
    output logic       wel_clr_o,
    output logic       bp_wr_o,
    output logic [1:0] bp_d_o,
    output logic       cyc_start_o,
    output logic       sak_o,
    output logic       tx_load_o,
    output logic [7:0] tx_byte_o,
    output logic       fill_req_o,
    output logic       fill_ones_o
);
    sse_state_e state_q, state_n;
    logic       sak_n, load_n, fill_n, ones_n;
    logic [7:0] tx_q;
    logic       sak_q, load_q, fill_q, ones_q;
    logic       fill_cmd;

    // Erase or fill opcode present.
    always_comb fill_cmd = (rx_byte_i == OP_ERAL) || (rx_byte_i == OP_SETAL);

    // Next state and per-byte decisions.
    always_comb begin
        state_n     = state_q;
        sak_n       = 1'b0;
        load_n      = 1'b0;
        fill_n      = 1'b0;
        ones_n      = ones_q;
        wel_set_o   = 1'b0;
        wel_clr_o   = 1'b0;
        bp_wr_o     = 1'b0;
        bp_d_o      = rx_byte_i[3:2];
        cyc_start_o = 1'b0;
        if (start_i) begin
            state_n = ST_ADDR;
        end else if (byte_valid_i) begin
            case (state_q)
                ST_ADDR: begin
                    state_n = ST_IDLE;
                    if (rx_byte_i == DEV_ADDR) begin
                        sak_n = 1'b1;
                        if (mak_i) state_n = ST_CMD;
                    end
                end
                ST_CMD: begin
                    state_n = ST_IDLE;
                    if (rx_byte_i == OP_RDSR) begin
                        sak_n = 1'b1;
                        if (mak_i) begin
                            load_n  = 1'b1;
                            state_n = ST_READ;
                        end
                    end else if (!wip_i) begin
                        if (rx_byte_i == OP_WREN && !mak_i) begin
                            sak_n     = 1'b1;
                            wel_set_o = 1'b1;
                        end else if (rx_byte_i == OP_WRDI && !mak_i) begin
                            sak_n     = 1'b1;
                            wel_clr_o = 1'b1;
                        end else if (rx_byte_i == OP_WRSR && mak_i && wel_i) begin
                            sak_n   = 1'b1;
                            state_n = ST_WDATA;
                        end else if (fill_cmd && !mak_i && wel_i && bp_i == 2'b00) begin
                            sak_n       = 1'b1;
                            cyc_start_o = 1'b1;
                            fill_n      = 1'b1;
                            ones_n      = (rx_byte_i == OP_SETAL);
                        end
                    end
                end
                ST_WDATA: begin
                    state_n = ST_IDLE;
                    if (!mak_i && wel_i && !wip_i) begin
                        sak_n       = 1'b1;
                        bp_wr_o     = 1'b1;
                        cyc_start_o = 1'b1;
                    end
                end
                ST_READ: begin
                    sak_n = 1'b1;
                    if (mak_i) load_n  = 1'b1;
                    else       state_n = ST_IDLE;
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // State and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sak_q   <= 1'b0;
            load_q  <= 1'b0;
            fill_q  <= 1'b0;
            ones_q  <= 1'b0;
            tx_q    <= 8'h00;
        end else begin
            state_q <= state_n;
            sak_q   <= sak_n;
            load_q  <= load_n;
            fill_q  <= fill_n;
            ones_q  <= ones_n;
            if (load_n) tx_q <= pack_status(wip_i, wel_i, bp_i);
        end
    end

    assign sak_o       = sak_q;
    assign tx_load_o   = load_q;
    assign tx_byte_o   = tx_q;
    assign fill_req_o  = fill_q;
    assign fill_ones_o = ones_q;
endmodule

// File: rtl/sse_status_engine.sv
// Top of the status command engine: sequencer, status bits and
// write-cycle timer.
// Assumes the physical layer supplies one-cycle byte and start pulses.
module sse_status_engine #(
    parameter logic [7:0] DEV_ADDR   = 8'hA0,
    parameter logic [7:0] OP_WREN    = 8'h96,
    parameter logic [7:0] OP_WRDI    = 8'h91,
    parameter logic [7:0] OP_RDSR    = 8'h05,
    parameter logic [7:0] OP_WRSR    = 8'h6E,
    parameter logic [7:0] OP_ERAL    = 8'h6D,
    parameter logic [7:0] OP_SETAL   = 8'h67,
    parameter int         TWC_CYCLES = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       byte_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       mak_i,
    output logic       sak_o,
    output logic       tx_load_o,
    output logic [7:0] tx_byte_o,
    output logic       fill_req_o,
    output logic       fill_ones_o,
    output logic       wip_o
);
    logic       wel;
    logic [1:0] bp;
    logic       wip;
    logic       cyc_done;
    logic       wel_set, wel_clr, bp_wr, cyc_start;
    logic [1:0] bp_d;

    sse_seq_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .OP_WREN  (OP_WREN),
        .OP_WRDI  (OP_WRDI),
        .OP_RDSR  (OP_RDSR),
        .OP_WRSR  (OP_WRSR),
        .OP_ERAL  (OP_ERAL),
        .OP_SETAL (OP_SETAL)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .rx_byte_i    (rx_byte_i),
        .mak_i        (mak_i),
        .wip_i        (wip),
        .wel_i        (wel),
        .bp_i         (bp),
        .wel_set_o    (wel_set),
        .wel_clr_o    (wel_clr),
        .bp_wr_o      (bp_wr),
        .bp_d_o       (bp_d),
        .cyc_start_o  (cyc_start),
        .sak_o        (sak_o),
        .tx_load_o    (tx_load_o),
        .tx_byte_o    (tx_byte_o),
        .fill_req_o   (fill_req_o),
        .fill_ones_o  (fill_ones_o)
    );

    sse_status_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wel_set_i  (wel_set),
        .wel_clr_i  (wel_clr),
        .cyc_done_i (cyc_done),
        .bp_wr_i    (bp_wr),
        .bp_d_i     (bp_d),
        .wel_o      (wel),
        .bp_o       (bp)
    );

    sse_wc_timer #(
        .TWC_CYCLES (TWC_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cyc_start),
        .busy_o  (wip),
        .done_o  (cyc_done)
    );

    assign wip_o = wip;
endmodule

// File: rtl/sse_status_engine_chk.sv
// Protocol checker for the status command engine, bound to the top.
module sse_status_engine_chk #(
    parameter logic [7:0] OP_WREN = 8'h96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_valid_i,
    input logic [7:0] rx_byte_i,
    input logic       mak_i,
    input logic       sak_o,
    input logic       tx_load_o,
    input logic [7:0] tx_byte_o,
    input logic       fill_req_o,
    input logic       wip_o,
    input logic       wel,
    input logic [1:0] bp
);
    a_r1_high_nibble_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> tx_byte_o[7:4] == 4'h0);

    a_r4_busy_bit_live: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> tx_byte_o[0] == $past(wip_o));

    a_r2_latch_set_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(byte_valid_i && !mak_i && rx_byte_i == OP_WREN));

    a_r10_no_set_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(wip_o));

    a_r8_fill_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> (wip_o && bp == 2'b00));

    a_r7_fill_needs_nomak: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_o |-> $past(byte_valid_i && !mak_i));

    a_r6_protect_needs_nomak: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp) |-> $past(byte_valid_i && !mak_i));

    a_r12_latch_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip_o) |-> !wel);

    a_r3_sak_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        sak_o |-> $past(byte_valid_i));
endmodule

bind sse_status_engine sse_status_engine_chk #(
    .OP_WREN (OP_WREN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid_i (byte_valid_i),
    .rx_byte_i    (rx_byte_i),
    .mak_i        (mak_i),
    .sak_o        (sak_o),
    .tx_load_o    (tx_load_o),
    .tx_byte_o    (tx_byte_o),
    .fill_req_o   (fill_req_o),
    .wip_o        (wip_o),
    .wel          (wel),
    .bp           (bp)
);

// File: tb/sse_status_engine_tb.sv
module sse_status_engine_tb;
    localparam int         CLK_PERIOD = 10;
    localparam int         TWC        = 20;
    localparam logic [7:0] DEV   = 8'hA0;
    localparam logic [7:0] WREN  = 8'h96;
    localparam logic [7:0] WRDI  = 8'h91;
    localparam logic [7:0] RDSR  = 8'h05;
    localparam logic [7:0] WRSR  = 8'h6E;
    localparam logic [7:0] ERAL  = 8'h6D;
    localparam logic [7:0] SETAL = 8'h67;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       byte_valid_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic       mak_i = 1'b0;
    logic       sak_o, tx_load_o, fill_req_o, fill_ones_o, wip_o;
    logic [7:0] tx_byte_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int fill_cnt = 0;
    logic last_ones = 1'b0;

    // Reference model of the status bits.
    logic       m_wel = 1'b0;
    logic [1:0] m_bp = 2'b00;
    logic       m_busy = 1'b0;
    int         m_cs = 0;

    logic [7:0] expq[$];
    string      reqq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sse_status_engine #(
        .DEV_ADDR (DEV), .OP_WREN (WREN), .OP_WRDI (WRDI), .OP_RDSR (RDSR),
        .OP_WRSR (WRSR), .OP_ERAL (ERAL), .OP_SETAL (SETAL), .TWC_CYCLES (TWC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_i (start_i),
        .byte_valid_i (byte_valid_i), .rx_byte_i (rx_byte_i), .mak_i (mak_i),
        .sak_o (sak_o), .tx_load_o (tx_load_o), .tx_byte_o (tx_byte_o),
        .fill_req_o (fill_req_o), .fill_ones_o (fill_ones_o), .wip_o (wip_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Predicted status byte as the design sees it in the current cycle.
    function automatic logic [7:0] pred();
        logic busy_now, wel_now;
        busy_now = m_busy && ((cyc - m_cs) < TWC);
        wel_now  = m_wel && !(m_busy && ((cyc - m_cs) >= TWC));
        return {4'b0000, m_bp, wel_now, busy_now};
    endfunction

    // Monitor: pops expected status bytes and counts fill requests.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_load_o) begin
                if (expq.size() == 0) chk("R4 unexpected load", 32'(tx_byte_o), 32'hFFFF);
                else chk(reqq.pop_front(), 32'(tx_byte_o), 32'(expq.pop_front()));
            end
            if (fill_req_o) begin
                fill_cnt++;
                last_ones = fill_ones_o;
            end
        end
    end

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    // Driver: one byte; pushes the expected status byte if a load should follow.
    task automatic send(input logic [7:0] b, input logic m, input logic exp_sak,
                        input logic exp_load, input string req);
        @(negedge clk);
        if (exp_load) begin
            expq.push_back(pred());
            reqq.push_back(req);
        end
        byte_valid_i = 1'b1; rx_byte_i = b; mak_i = m;
        @(negedge clk);
        byte_valid_i = 1'b0;
        chk(req, 32'(sak_o), 32'(exp_sak));
    endtask

    task automatic cmd1(input logic [7:0] op, input logic m, input logic exp_sak,
                        input string req);
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, req);
        send(op, m, exp_sak, 1'b0, req);
    endtask

    task automatic rd_status(input int polls, input string req);
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, req);
        send(RDSR, 1'b1, 1'b1, 1'b1, req);
        for (int i = 0; i < polls; i++) send(8'h00, 1'b1, 1'b1, 1'b1, req);
        send(8'h00, 1'b0, 1'b1, 1'b0, req);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && wip_o; i++) @(negedge clk);
        if (m_busy) begin
            m_busy = 1'b0;
            m_wel  = 1'b0;
        end
    endtask

    task automatic mark_cycle();
        m_busy = 1'b1;
        m_cs   = cyc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 sak in reset", 32'(sak_o), 0);
        chk("R13 wip in reset", 32'(wip_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 load idle", 32'(tx_load_o), 0);
        chk("R13 fill idle", 32'(fill_req_o), 0);
        rd_status(1, "R13 status after reset");

        // Enable with MAK is invalid, with NoMAK works; disable clears.
        cmd1(WREN, 1'b1, 1'b0, "R7 enable with MAK");
        rd_status(0, "R7 latch unchanged");
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        rd_status(0, "R2 latch set");
        cmd1(WRDI, 1'b0, 1'b1, "R2 disable");
        m_wel = 1'b0;
        rd_status(0, "R2 latch clear");

        // Wrong device address mutes the transaction.
        do_start();
        send(8'h55, 1'b1, 1'b0, 1'b0, "R3 wrong address");
        send(RDSR, 1'b1, 1'b0, 1'b0, "R3 read muted");
        send(8'h00, 1'b1, 1'b0, 1'b0, "R3 slot muted");

        cmd1(8'h3C, 1'b0, 1'b0, "R14 unknown NoMAK");
        cmd1(8'h3C, 1'b1, 1'b0, "R14 unknown MAK");

        // Latch clear: write-type commands refused.
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R11");
        send(WRSR, 1'b1, 1'b0, 1'b0, "R11 status write without latch");
        cmd1(ERAL, 1'b0, 1'b0, "R11 erase without latch");
        @(negedge clk);
        chk("R11 no fill", 32'(fill_cnt), 0);
        rd_status(0, "R11 status unchanged");

        // Status write ending with MAK is invalid.
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R7");
        send(WRSR, 1'b1, 1'b1, 1'b0, "R7 opcode");
        send(8'h0C, 1'b1, 1'b0, 1'b0, "R7 data with MAK");
        rd_status(0, "R7 protect unchanged");

        // Valid status write, then a polled read across the cycle end.
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R6");
        send(WRSR, 1'b1, 1'b1, 1'b0, "R6 opcode");
        send(8'hF4, 1'b0, 1'b1, 1'b0, "R6 data");
        m_bp = 2'b01;
        mark_cycle();
        chk("R6 cycle started", 32'(wip_o), 1);
        rd_status(12, "R4 live poll");
        wait_idle();
        rd_status(0, "R12 latch clear after cycle");

        // Protection blocks erase and fill.
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        cmd1(ERAL, 1'b0, 1'b0, "R9 erase protected");
        cmd1(SETAL, 1'b0, 1'b0, "R9 fill protected");
        @(negedge clk);
        chk("R9 no fill", 32'(fill_cnt), 0);
        rd_status(0, "R9 status");

        // Commands during a write cycle.
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R6");
        send(WRSR, 1'b1, 1'b1, 1'b0, "R6 opcode");
        send(8'h00, 1'b0, 1'b1, 1'b0, "R6 unprotect");
        m_bp = 2'b00;
        mark_cycle();
        cmd1(WREN, 1'b0, 1'b0, "R10 enable while busy");
        cmd1(ERAL, 1'b0, 1'b0, "R10 erase while busy");
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R10");
        send(WRSR, 1'b1, 1'b0, 1'b0, "R10 status write while busy");
        rd_status(0, "R5 read while busy");
        wait_idle();
        @(negedge clk);
        chk("R10 no fill", 32'(fill_cnt), 0);
        rd_status(0, "R12 after cycle");

        // Erase: fill request and exact cycle length.
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        cmd1(ERAL, 1'b0, 1'b1, "R8 erase");
        begin
            int n;
            n = 0;
            while (wip_o && n < 200) begin
                @(negedge clk);
                n++;
            end
            chk("R12 cycle length", 32'(n), 32'(TWC));
        end
        m_busy = 1'b0;
        m_wel  = 1'b0;
        chk("R8 one fill", 32'(fill_cnt), 1);
        chk("R8 zero value", 32'(last_ones), 0);
        rd_status(0, "R12 latch cleared by erase cycle");

        // Fill: MAK is invalid, NoMAK works.
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        cmd1(SETAL, 1'b1, 1'b0, "R7 fill with MAK");
        @(negedge clk);
        chk("R7 no fill", 32'(fill_cnt), 1);
        cmd1(SETAL, 1'b0, 1'b1, "R8 fill");
        mark_cycle();
        @(negedge clk);
        chk("R8 second fill", 32'(fill_cnt), 2);
        chk("R8 ones value", 32'(last_ones), 1);
        wait_idle();

        // Both protect bits, high nibble discarded.
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        do_start();
        send(DEV, 1'b1, 1'b1, 1'b0, "R1");
        send(WRSR, 1'b1, 1'b1, 1'b0, "R1 opcode");
        send(8'hFF, 1'b0, 1'b1, 1'b0, "R1 data");
        m_bp = 2'b11;
        mark_cycle();
        wait_idle();
        rd_status(0, "R1 protect bits");
        cmd1(WREN, 1'b0, 1'b1, "R2 enable");
        m_wel = 1'b1;
        rd_status(0, "R1 full layout");

        // Reset mid-run clears everything.
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_wel = 1'b0;
        m_bp  = 2'b00;
        rd_status(0, "R13 status after second reset");

        repeat (3) @(negedge clk);
        chk("R4 queue drained", 32'(expq.size()), 0);
        report();
    end
endmodule